// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge Interrupts

This block gives a chip sixteen general-purpose pins that are controlled through a byte-wide register bus. The pins are split into two banks of eight: pins 0-7 form bank 0 and pins 8-15 form bank 1. Each pin has two one-byte registers. The drive register sets the direction, push-pull or open-drain drive, the pull selection and the output value. The sense register returns the synchronised pin level and selects which edges raise an interrupt.

Pin inputs pass through a two-flop synchroniser before they reach the level readback and the edge detector. Selected edges latch into a pending register per bank, and software clears those bits by writing 1 to them. A mask register per bank gates which pending bits reach the single interrupt output. A second mask pair is provided for software and has no effect in hardware. Pull and open-drain settings exist only as register bits and as the output-enable behaviour; no analog pad behaviour is modelled.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, no pin is driven (`pin_oe` all 0) and `irq` is low.
- R2: The drive register of pin n is at 0x2B+n for bank 0 and at 0x3B+(n-8) for bank 1. Bits 5:0 are writable and read back; bits 7:6 read 0. Read data appears on `bus_rdata` one clock after the edge that samples `bus_re`.
- R3: With drive bit 5 = 1 (output) and bit 4 = 0 (push-pull), the pin is driven (`pin_oe`=1) and `pin_out` equals drive bit 0.
- R4: With drive bit 5 = 1 and bit 4 = 1 (open-drain), the pin is driven low when bit 0 = 0, and it is released (`pin_oe`=0) when bit 0 = 1.
- R5: With drive bit 5 = 0 (input), the pin is never driven, whatever the other bits hold.
- R6: The sense register of pin n is at 0x33+n for bank 0 and at 0x43+(n-8) for bank 1. Bits 2:1 hold the edge mode and are writable. Bit 0 reads the pin level after two synchroniser flops. Bits 7:3 read 0.
- R7: Edge mode 0 detects nothing, 1 detects falling edges, 2 detects rising edges and 3 detects both. A detected edge sets pending bit n%8 in register 0x1D (bank 0) or 0x1E (bank 1).
- R8: Writing the pending register clears exactly the bits written as 1. Bits written as 0 stay as they were.
- R9: When an edge on a pin and a clear write to the same pending bit fall in the same cycle, the bit stays set.
- R10: Mask registers 0x19 (bank 0) and 0x1A (bank 1): a 1 keeps that pin's pending bit away from `irq`, but the pending bit is still latched.
- R11: Mask registers 0x1B and 0x1C are readable and writable and have no effect on `irq`.
- R12: `irq` is the OR, over both banks, of the pending bits whose 0x19/0x1A mask bit is 0. It stays high until all such bits are cleared.
- R13: Unmapped addresses read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The collision that matters is between an edge detected on a pin and a software write that clears the same pending bit. The bench sets the pending bit first. It then toggles the pin and places the clear write so that the bus write is sampled on the one clock edge where the synchronised edge pulse is high. The bit must read back as still set, and a later clear with no edge must then remove it. A second case writes a pending register with a mix of 1 and 0 bits and checks that only the bits written as 1 were cleared.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int unsigned DATA_W = 8;

  // Address map: the second bank sits 16 bytes above the first.
  function automatic logic [7:0] drv_base(input int b);
    return 8'(8'h2B + 16 * b);
  endfunction

  function automatic logic [7:0] sns_base(input int b);
    return 8'(8'h33 + 16 * b);
  endfunction

  function automatic logic [7:0] mask_addr(input int b);
    return 8'(8'h19 + b);
  endfunction

  function automatic logic [7:0] shadow_addr(input int b);
    return 8'(8'h1B + b);
  endfunction

  function automatic logic [7:0] pend_addr(input int b);
    return 8'(8'h1D + b);
  endfunction

  // mode[1] selects rising edges, mode[0] selects falling edges
  function automatic logic edge_fire(input logic [1:0] mode, input logic cur, input logic prev);
    return (mode[1] & cur & ~prev) | (mode[0] & ~cur & prev);
  endfunction

  // Returns {oe, out} from the drive register bits
  function automatic logic [1:0] pad_drive(input logic [5:0] drv);
    logic oe, val;
    val = drv[0];
    oe  = drv[5] & (~drv[4] | ~val);
    return {oe, val & ~drv[4]};
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= d;
      lvl      <= meta_q;
      lvl_prev <= lvl;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned LANES       = 8,
  parameter logic [7:0]  DRV_BASE    = 8'h2B,
  parameter logic [7:0]  SNS_BASE    = 8'h33,
  parameter logic [7:0]  MASK_ADDR   = 8'h19,
  parameter logic [7:0]  SHADOW_ADDR = 8'h1B,
  parameter logic [7:0]  PEND_ADDR   = 8'h1D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             we,
  input  logic [LANES-1:0] lvl,
  input  logic [LANES-1:0] lvl_prev,
  output logic [7:0]       rd_data,
  output logic [LANES-1:0] pad_oe,
  output logic [LANES-1:0] pad_out,
  output logic [LANES-1:0] pend_q,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] dir_v,
  output logic [LANES-1:0] od_v,
  output logic [LANES-1:0] edge_hit,
  output logic [LANES-1:0] clr_req
);
  logic [5:0]       drv_q  [LANES];
  logic [1:0]       mode_q [LANES];
  logic [LANES-1:0] shadow_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [7:0] DA = 8'(DRV_BASE + i);
    localparam logic [7:0] SA = 8'(SNS_BASE + i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        drv_q[i]  <= '0;
        mode_q[i] <= '0;
      end else if (we) begin
        if (addr == DA) drv_q[i]  <= wdata[5:0];
        if (addr == SA) mode_q[i] <= wdata[2:1];
      end
    end

    assign edge_hit[i]             = edge_fire(mode_q[i], lvl[i], lvl_prev[i]);
    assign {pad_oe[i], pad_out[i]} = pad_drive(drv_q[i]);
    assign dir_v[i]                = drv_q[i][5];
    assign od_v[i]                 = drv_q[i][4];
  end

  assign clr_req = (we && addr == PEND_ADDR) ? wdata[LANES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      shadow_q <= '0;
      pend_q   <= '0;
    end else begin
      if (we && addr == MASK_ADDR)   mask_q   <= wdata[LANES-1:0];
      if (we && addr == SHADOW_ADDR) shadow_q <= wdata[LANES-1:0];
      pend_q <= (pend_q & ~clr_req) | edge_hit;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < LANES; k++) begin
      if (addr == 8'(DRV_BASE + k)) rd_data = {2'b00, drv_q[k]};
      if (addr == 8'(SNS_BASE + k)) rd_data = {5'b0, mode_q[k], lvl[k]};
    end
    if (addr == MASK_ADDR)   rd_data = 8'(mask_q);
    if (addr == SHADOW_ADDR) rd_data = 8'(shadow_q);
    if (addr == PEND_ADDR)   rd_data = 8'(pend_q);
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned BANKS = 2,
  parameter int unsigned LANES = 8,
  localparam int unsigned PINS = BANKS * LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [7:0]      bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq
);
  logic [PINS-1:0] lvl, lvl_prev;
  logic [PINS-1:0] pend_all, mask_all, dir_all, od_all, edge_all, clr_all;
  logic [7:0]      bank_rd [BANKS];
  logic [7:0]      rd_mux;

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gpio_bank #(
      .LANES(LANES),
      .DRV_BASE(drv_base(b)),
      .SNS_BASE(sns_base(b)),
      .MASK_ADDR(mask_addr(b)),
      .SHADOW_ADDR(shadow_addr(b)),
      .PEND_ADDR(pend_addr(b))
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
      .lvl(lvl[b*LANES +: LANES]),
      .lvl_prev(lvl_prev[b*LANES +: LANES]),
      .rd_data(bank_rd[b]),
      .pad_oe(pin_oe[b*LANES +: LANES]),
      .pad_out(pin_out[b*LANES +: LANES]),
      .pend_q(pend_all[b*LANES +: LANES]),
      .mask_q(mask_all[b*LANES +: LANES]),
      .dir_v(dir_all[b*LANES +: LANES]),
      .od_v(od_all[b*LANES +: LANES]),
      .edge_hit(edge_all[b*LANES +: LANES]),
      .clr_req(clr_all[b*LANES +: LANES])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < BANKS; b++) rd_mux |= bank_rd[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign irq = |(pend_all & ~mask_all);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int unsigned PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] pend,
  input logic [PINS-1:0] mask,
  input logic [PINS-1:0] dir,
  input logic [PINS-1:0] od,
  input logic [PINS-1:0] edge_hit,
  input logic [PINS-1:0] clr_req,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pin_out,
  input logic            irq
);
  AST_IN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir) == '0); // R5

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & od & pin_out) == '0); // R4

  AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit == '0) |=> ((pend & ~$past(pend)) == '0)); // R7

  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & clr_req) != '0) |=> ((pend & $past(edge_hit & clr_req)) == $past(edge_hit & clr_req))); // R9

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & ~edge_hit) != '0) |=> ((pend & $past(clr_req & ~edge_hit)) == '0)); // R8

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & ~mask) != '0)); // R12

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq); // R10
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend_all), .mask(mask_all), .dir(dir_all),
  .od(od_all), .edge_hit(edge_all), .clr_req(clr_all), .pin_oe(pin_oe),
  .pin_out(pin_out), .irq(irq)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0;
  logic        bus_we = 0, bus_re = 0;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_in = 0, pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {address, write data, expected read-back}
  localparam logic [23:0] VEC [8] = '{
    {8'h2B, 8'hFF, 8'h3F},  // R2 bank0 pin0, upper bits dropped
    {8'h32, 8'h21, 8'h21},  // R2 bank0 pin7
    {8'h3B, 8'h15, 8'h15},  // R2 bank1 pin8
    {8'h42, 8'h08, 8'h08},  // R2 bank1 pin15
    {8'h33, 8'hFF, 8'h06},  // R6 only mode bits stick, level 0
    {8'h4A, 8'h04, 8'h04},  // R6 bank1 pin15
    {8'h1B, 8'hA5, 8'hA5},  // R11 shadow mask
    {8'h00, 8'h77, 8'h00}   // R13 unmapped
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic setpin(input int idx, input logic v);
    @(negedge clk);
    pin_in[idx] = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    pin_in = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    logic [7:0] r;
    do_reset();

    // Table walk: write then read back each register
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], r);
      chk($sformatf("R2/R6/R11/R13 vec%0d", i), 16'(r), 16'(VEC[i][7:0]));
    end
    rd(8'h2B, r);
    chk("R13 unmapped write left pin0 drive", 16'(r), 16'h3F);

    // R1 reset state
    do_reset();
    chk("R1 oe", pin_oe, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    rd(8'h2B, r); chk("R1 drive reg", 16'(r), 16'h0);
    rd(8'h1B, r); chk("R1 shadow mask", 16'(r), 16'h0);
    rd(8'h1D, r); chk("R1 pending", 16'(r), 16'h0);

    // R3 push-pull
    wr(8'h2B, 8'h21);
    chk("R3 pp high oe", 16'(pin_oe[0]), 16'h1);
    chk("R3 pp high out", 16'(pin_out[0]), 16'h1);
    wr(8'h2B, 8'h20);
    chk("R3 pp low oe/out", 16'({pin_oe[0], pin_out[0]}), 16'b10);

    // R4 open-drain on pin 9
    wr(8'h3C, 8'h31);
    chk("R4 od release", 16'(pin_oe[9]), 16'h0);
    wr(8'h3C, 8'h30);
    chk("R4 od drive low", 16'({pin_oe[9], pin_out[9]}), 16'b10);

    // R5 input direction never drives (pin 1)
    wr(8'h2C, 8'h1F);
    chk("R5 input no drive", 16'(pin_oe[1]), 16'h0);

    // R6 level readback pin 12, mode 0
    setpin(12, 1);
    rd(8'h47, r); chk("R6 level", 16'(r), 16'h01);
    rd(8'h1E, r); chk("R7 mode0 no pending", 16'(r), 16'h0);

    // R7 rising on pin 3
    wr(8'h36, 8'h04);
    setpin(3, 1);
    rd(8'h1D, r); chk("R7 rise pending", 16'(r), 16'h08);
    chk("R12 irq on", 16'(irq), 16'h1);
    wr(8'h1D, 8'h08);
    chk("R12 irq off after clear", 16'(irq), 16'h0);
    setpin(3, 0);
    rd(8'h1D, r); chk("R7 rise mode ignores fall", 16'(r), 16'h0);

    // R7 falling on pin 10
    wr(8'h45, 8'h02);
    setpin(10, 1);
    rd(8'h1E, r); chk("R7 fall mode ignores rise", 16'(r), 16'h0);
    setpin(10, 0);
    rd(8'h1E, r); chk("R7 fall pending", 16'(r), 16'h04);

    // R7 both edges on pin 15, R8 partial clear
    wr(8'h4A, 8'h06);
    setpin(15, 1);
    rd(8'h1E, r); chk("R7 both rise", 16'(r), 16'h84);
    wr(8'h1E, 8'h80);
    rd(8'h1E, r); chk("R8 clears only ones", 16'(r), 16'h04);
    setpin(15, 0);
    rd(8'h1E, r); chk("R7 both fall", 16'(r), 16'h84);
    wr(8'h1E, 8'hFF);
    rd(8'h1E, r); chk("R8 full clear", 16'(r), 16'h0);

    // R10 mask
    wr(8'h19, 8'h08);
    setpin(3, 1);
    rd(8'h1D, r); chk("R10 pending latched while masked", 16'(r), 16'h08);
    chk("R10 irq masked", 16'(irq), 16'h0);
    wr(8'h19, 8'h00);
    chk("R10 irq after unmask", 16'(irq), 16'h1);
    wr(8'h1D, 8'hFF);

    // R11 shadow mask has no effect
    wr(8'h1B, 8'hFF);
    setpin(3, 0);
    setpin(3, 1);
    chk("R11 shadow mask no effect", 16'(irq), 16'h1);
    wr(8'h1D, 8'h08);
    chk("R12 irq clears", 16'(irq), 16'h0);

    // R9 edge and clear in the same cycle (pin 15, both edges)
    setpin(15, 1);
    @(negedge clk);
    pin_in[15] = 0;
    @(posedge clk);
    @(posedge clk);      // edge pulse now high until next edge
    wr(8'h1E, 8'h80);    // write sampled on that next edge
    rd(8'h1E, r); chk("R9 edge wins over clear", 16'(r), 16'h80);
    chk("R9 irq held", 16'(irq), 16'h1);
    wr(8'h1E, 8'h80);
    rd(8'h1E, r); chk("R8 clear after collision", 16'(r), 16'h0);
    chk("R12 irq low at end", 16'(irq), 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule